// File: doc/BRIEF.md
# Bit-Enabled PHY Control Register Bank

This block is a small bank of 32-bit control registers on a simple single-cycle register bus. Each register keeps state only in its low 16 bits. The high 16 bits of every write word act as a per-bit write enable: a low-half bit is updated only when its partner enable bit is set. Software can therefore change one field without first reading the register back.

The bank has three registers. The configuration register drives a strobe, a 6-bit PHY-side register address and a 4-bit data field toward an attached PHY. The lane-disable register holds one off bit for each of four lanes. The read-only status register reports two PLL conditions, which are sampled from input pins. Reads return data combinationally in the cycle they are presented. Writes take effect on the next rising clock edge. An access to any other offset returns zero and raises an error flag for one cycle.

Top module: `phyreg_bank`

## Requirements
- R1: On a write to a writable register, low-half bit x takes bit x of the write word when bit x+16 of the same word is 1. Otherwise bit x keeps its previous value.
- R2: In the configuration register, bit 0 drives `cfg_strobe`, bits 6:1 drive `cfg_addr` and bits 10:7 drive `cfg_data`. The outputs change at the clock edge that ends the write cycle.
- R3: In the lane-disable register, bits 3, 4, 5 and 6 drive `lane_off[0]` to `lane_off[3]`. A 1 means the lane is off.
- R4: The synchronous active-low reset sets the configuration register to 0x0000 and the lane-disable register to 0x0078 (all lanes off). It clears the captured status bits and the error flag.
- R5: While `bus_sel` is high, `bus_rdata` shows the low-half contents of the addressed register in the same cycle. While `bus_sel` is low, it reads zero.
- R6: Bits 31:16 of `bus_rdata` always read as zero.
- R7: Status bit 9 is `pll_lock_in` and status bit 10 is `pll_outen_in`, both sampled at the previous clock edge. All other status bits read as zero. Writes to the status offset change no register.
- R8: An access with `bus_sel` high to an offset outside the three mapped ones reads zero. It makes `bus_err` high in the following cycle, for one cycle per access cycle. A mapped access leaves `bus_err` low.
- R9: The lane-disable register is at offset 0xE214, the configuration register at 0xE220 and the status register at 0xE2A4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the access |
| bus_wdata | input | 32 | Write word: 31:16 enables, 15:0 data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | One-cycle flag after an unmapped access |
| cfg_strobe | output | 1 | PHY configuration write strobe |
| cfg_addr | output | 6 | PHY-side register address |
| cfg_data | output | 4 | PHY-side write data |
| lane_off | output | 4 | Per-lane off control, 1 = off |
| pll_lock_in | input | 1 | PLL locked indication from the PHY |
| pll_outen_in | input | 1 | PLL output-enable condition from the PHY |

## Verification
The configuration register is swept with 256 arithmetically generated pairs of data and enable words. The sweep includes an all-clear enable, which shows that bits hold, and sparse and dense enables, which show that each bit is gated by its own enable and not by a neighbour's. For every pair the bench compares readback and the three output fields against a reference value built as (old & ~enable) | (data & enable). The lane-disable register gets every combination of the four lane enables against every lane data nibble, with stray bits set in both halves. This separates a lane-to-bit mapping error from an enable error. The bench also walks all four status input combinations, writes all-ones to the status offset, and probes the addresses next to each mapped offset. Together these show the one-cycle sampling, that status writes change nothing, and that the offset decode is exact.

// File: rtl/phyreg_pkg.sv
// Package: shared widths and the register select encoding for the bank.
// Assumes a 32-bit bus word split into two equal halves.
package phyreg_pkg;
    localparam int BUS_W  = 32;
    localparam int HALF_W = BUS_W / 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LANE = 2'd1,
        SEL_CFG  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/phyreg_decode.sv
// Module: offset decoder. Maps a byte offset to one of the three registers,
// or to SEL_NONE. Assumes the three offset parameters are distinct.
module phyreg_decode
    import phyreg_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] LANE_OFS = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS  = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'hE2A4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    // Exact match against each mapped offset.
    always_comb begin
        if (addr == LANE_OFS)      sel = SEL_LANE;
        else if (addr == CFG_OFS)  sel = SEL_CFG;
        else if (addr == STAT_OFS) sel = SEL_STAT;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/phyreg_mask_reg.sv
// Module: one storage register with a per-bit write enable. A bit is
// updated only when the write is accepted and its own enable bit is set.
// Assumes data and enable arrive in the same cycle as the write request.
module phyreg_mask_reg #(
    parameter int            W       = 16,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wd,
    input  logic [W-1:0] en,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    // Per-bit merge: new data where enabled, current value elsewhere.
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign nxt[gi] = en[gi] ? wd[gi] : q[gi];
    end

    // Register the merged value on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= nxt;
    end
endmodule

// File: rtl/phyreg_status_cap.sv
// Module: samples the PHY status pins once per clock and places them at
// their bit positions in a read-only status word. Other bits read zero.
// Assumes the pins are synchronous to clk.
module phyreg_status_cap #(
    parameter int W         = 16,
    parameter int LOCK_BIT  = 9,
    parameter int OUTEN_BIT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lock_in,
    input  logic         outen_in,
    output logic [W-1:0] stat
);
    logic lock_q;
    logic outen_q;

    // Capture the status pins each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= 1'b0;
            outen_q <= 1'b0;
        end else begin
            lock_q  <= lock_in;
            outen_q <= outen_in;
        end
    end

    // Assemble the status word from the captured bits.
    always_comb begin
        stat            = '0;
        stat[LOCK_BIT]  = lock_q;
        stat[OUTEN_BIT] = outen_q;
    end
endmodule

// File: rtl/phyreg_bank.sv
// Module: top of the bit-enabled PHY control register bank. Decodes bus
// accesses, applies enabled writes to the configuration and lane registers,
// returns readback combinationally and flags unmapped offsets one cycle
// later. Assumes a single-cycle bus with no wait states.
module phyreg_bank
    import phyreg_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] LANE_OFS   = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS    = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS   = 16'hE2A4,
    parameter int                N_LANES    = 4,
    parameter int                LANE_LSB   = 3,
    parameter int                CFG_ADDR_W = 6,
    parameter int                CFG_DATA_W = 4,
    parameter int                LOCK_BIT   = 9,
    parameter int                OUTEN_BIT  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata,
    output logic                  bus_err,
    output logic                  cfg_strobe,
    output logic [CFG_ADDR_W-1:0] cfg_addr,
    output logic [CFG_DATA_W-1:0] cfg_data,
    output logic [N_LANES-1:0]    lane_off,
    input  logic                  pll_lock_in,
    input  logic                  pll_outen_in
);
    localparam int              CFG_ADDR_LSB = 1;
    localparam int              CFG_DATA_LSB = CFG_ADDR_LSB + CFG_ADDR_W;
    localparam logic [HALF_W-1:0] LANE_RST =
        HALF_W'(((1 << N_LANES) - 1) << LANE_LSB);

    reg_sel_e            dec_sel;
    logic [HALF_W-1:0]   wr_data;
    logic [HALF_W-1:0]   wr_en;
    logic                lane_we;
    logic                cfg_we;
    logic [HALF_W-1:0]   lane_q;
    logic [HALF_W-1:0]   cfg_q;
    logic [HALF_W-1:0]   stat_w;
    logic [HALF_W-1:0]   rd_half;
    logic                err_q;

    phyreg_decode #(
        .ADDR_W  (ADDR_W),
        .LANE_OFS(LANE_OFS),
        .CFG_OFS (CFG_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_decode (
        .addr(bus_addr),
        .sel (dec_sel)
    );

    // Split the write word into data and enable halves.
    assign wr_data = bus_wdata[HALF_W-1:0];
    assign wr_en   = bus_wdata[BUS_W-1:HALF_W];

    // Write requests per register; the status register takes none.
    assign lane_we = bus_sel && bus_wr && (dec_sel == SEL_LANE);
    assign cfg_we  = bus_sel && bus_wr && (dec_sel == SEL_CFG);

    phyreg_mask_reg #(
        .W      (HALF_W),
        .RST_VAL(LANE_RST)
    ) u_lane_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (lane_we),
        .wd   (wr_data),
        .en   (wr_en),
        .q    (lane_q)
    );

    phyreg_mask_reg #(
        .W      (HALF_W),
        .RST_VAL('0)
    ) u_cfg_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .wd   (wr_data),
        .en   (wr_en),
        .q    (cfg_q)
    );

    phyreg_status_cap #(
        .W        (HALF_W),
        .LOCK_BIT (LOCK_BIT),
        .OUTEN_BIT(OUTEN_BIT)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_in (pll_lock_in),
        .outen_in(pll_outen_in),
        .stat    (stat_w)
    );

    // Readback mux; unselected or unmapped accesses return zero.
    always_comb begin
        rd_half = '0;
        if (bus_sel) begin
            case (dec_sel)
                SEL_LANE: rd_half = lane_q;
                SEL_CFG:  rd_half = cfg_q;
                SEL_STAT: rd_half = stat_w;
                default:  rd_half = '0;
            endcase
        end
    end

    assign bus_rdata = {{HALF_W{1'b0}}, rd_half};

    // Flag an access to an unmapped offset for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bus_sel && (dec_sel == SEL_NONE);
    end

    assign bus_err = err_q;

    // Field outputs toward the PHY.
    assign cfg_strobe = cfg_q[0];
    assign cfg_addr   = cfg_q[CFG_ADDR_LSB +: CFG_ADDR_W];
    assign cfg_data   = cfg_q[CFG_DATA_LSB +: CFG_DATA_W];
    assign lane_off   = lane_q[LANE_LSB +: N_LANES];
endmodule

// File: rtl/phyreg_bank_chk.sv
// Module: property checker for phyreg_bank, attached with bind below.
// Works only from the top-level ports and parameters.
module phyreg_bank_chk #(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] LANE_OFS   = 16'hE214,
    parameter logic [ADDR_W-1:0] CFG_OFS    = 16'hE220,
    parameter logic [ADDR_W-1:0] STAT_OFS   = 16'hE2A4,
    parameter int                N_LANES    = 4,
    parameter int                LANE_LSB   = 3,
    parameter int                CFG_ADDR_W = 6,
    parameter int                CFG_DATA_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic                  bus_err,
    input logic                  cfg_strobe,
    input logic [CFG_ADDR_W-1:0] cfg_addr,
    input logic [CFG_DATA_W-1:0] cfg_data,
    input logic [N_LANES-1:0]    lane_off
);
    logic unmapped;
    assign unmapped = (bus_addr != LANE_OFS) && (bus_addr != CFG_OFS) &&
                      (bus_addr != STAT_OFS);

    AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == CFG_OFS && !bus_wdata[16]
        |=> $stable(cfg_strobe)); // R1
    AST_STROBE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == CFG_OFS && bus_wdata[16]
        |=> cfg_strobe == $past(bus_wdata[0])); // R2
    AST_LANE0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == LANE_OFS && bus_wdata[16+LANE_LSB]
        |=> lane_off[0] == $past(bus_wdata[LANE_LSB])); // R3
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0000); // R6
    AST_STAT_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == STAT_OFS
        |=> $stable(cfg_addr) && $stable(cfg_data) && $stable(lane_off)); // R7
    AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && unmapped |=> bus_err); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && unmapped) |=> !bus_err); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && unmapped |-> bus_rdata == 32'h0); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |-> bus_rdata == 32'h0); // R5
endmodule

bind phyreg_bank phyreg_bank_chk #(
    .ADDR_W    (ADDR_W),
    .LANE_OFS  (LANE_OFS),
    .CFG_OFS   (CFG_OFS),
    .STAT_OFS  (STAT_OFS),
    .N_LANES   (N_LANES),
    .LANE_LSB  (LANE_LSB),
    .CFG_ADDR_W(CFG_ADDR_W),
    .CFG_DATA_W(CFG_DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .cfg_strobe(cfg_strobe),
    .cfg_addr  (cfg_addr),
    .cfg_data  (cfg_data),
    .lane_off  (lane_off)
);

// File: tb/phyreg_bank_bench.sv
// Bench: sweeps of enabled writes against a reference merge computed here.
module phyreg_bank_bench;
    localparam logic [15:0] A_LANE = 16'hE214;
    localparam logic [15:0] A_CFG  = 16'hE220;
    localparam logic [15:0] A_STAT = 16'hE2A4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        cfg_strobe;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_data;
    logic [3:0]  lane_off;
    logic        pll_lock_in = 1'b0;
    logic        pll_outen_in = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] cfg_m;
    logic [15:0] lane_m;

    always #5 clk = ~clk;

    phyreg_bank u_phyreg_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .cfg_strobe(cfg_strobe), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .lane_off(lane_off),
        .pll_lock_in(pll_lock_in), .pll_outen_in(pll_outen_in)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write at a falling edge; committed at the next rising edge.
    task automatic do_write(input logic [15:0] a, input logic [31:0] w);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read combinationally just after a falling edge.
    task automatic do_read(input logic [15:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cfg_m = 16'h0000;
        lane_m = 16'h0078;
        // R4 reset state
        chk("R4 err", {31'b0, bus_err}, 32'h0);
        chk("R4 lane_off", {28'b0, lane_off}, 32'hF);
        chk("R5 idle read", bus_rdata, 32'h0);
        do_read(A_CFG, v);  chk("R4 cfg", v, 32'h0);
        do_read(A_LANE, v); chk("R4 lane", v, 32'h78);
        do_read(A_STAT, v); chk("R4 stat", v, 32'h0);

        // R1 R2 R9 config sweep
        for (int i = 0; i < 256; i++) begin
            logic [15:0] d, m;
            d = 16'(i * 40503 + 7);
            m = 16'((i * 13933) ^ (i << 9));
            cfg_m = (cfg_m & ~m) | (d & m);
            do_write(A_CFG, {m, d});
            chk("R2 strobe", {31'b0, cfg_strobe}, {31'b0, cfg_m[0]});
            chk("R2 addr", {26'b0, cfg_addr}, {26'b0, cfg_m[6:1]});
            chk("R2 data", {28'b0, cfg_data}, {28'b0, cfg_m[10:7]});
            do_read(A_CFG, v);
            chk("R1 cfg readback", v, {16'h0, cfg_m});
        end
        chk("R8 mapped no err", {31'b0, bus_err}, 32'h0);

        // R3 lane sweep: all lane enables against all lane data
        for (int mi = 0; mi < 16; mi++) begin
            for (int di = 0; di < 16; di++) begin
                logic [15:0] d, m;
                m = 16'(mi << 3) | ((mi == 5) ? 16'h8001 : 16'h0);
                d = 16'(di << 3) | 16'hA405;
                lane_m = (lane_m & ~m) | (d & m);
                do_write(A_LANE, {m, d});
                chk("R3 lane_off", {28'b0, lane_off}, {28'b0, lane_m[6:3]});
                do_read(A_LANE, v);
                chk("R1 lane readback", v, {16'h0, lane_m});
            end
        end

        // R6 full-enable write, upper half reads zero
        cfg_m = 16'hFFFF;
        do_write(A_CFG, 32'hFFFF_FFFF);
        do_read(A_CFG, v);
        chk("R6 upper zero", v, 32'h0000_FFFF);

        // R7 status sampling, all input combinations
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            pll_lock_in = s[0]; pll_outen_in = s[1];
            @(negedge clk);
            do_read(A_STAT, v);
            chk("R7 status", v, 32'(s[0]) << 9 | 32'(s[1]) << 10);
        end
        pll_lock_in = 1'b0; pll_outen_in = 1'b0;
        @(negedge clk);

        // R7 status write ignored
        do_write(A_STAT, 32'hFFFF_FFFF);
        do_read(A_STAT, v); chk("R7 stat write", v, 32'h0);
        do_read(A_CFG, v);  chk("R7 cfg untouched", v, {16'h0, cfg_m});
        do_read(A_LANE, v); chk("R7 lane untouched", v, {16'h0, lane_m});

        // R8 R9 neighbouring and far offsets are unmapped
        for (int k = 0; k < 8; k++) begin
            logic [15:0] a;
            case (k)
                0: a = A_LANE - 16'd4;  1: a = A_LANE + 16'd4;
                2: a = A_CFG - 16'd4;   3: a = A_CFG + 16'd4;
                4: a = A_STAT - 16'd4;  5: a = A_STAT + 16'd4;
                6: a = 16'h0000;        default: a = 16'hFFFF;
            endcase
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = k[0]; bus_addr = a;
            bus_wdata = 32'hFFFF_FFFF;
            #1 chk("R8 unmapped read", bus_rdata, 32'h0);
            @(negedge clk);
            bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
            chk("R8 err raised", {31'b0, bus_err}, 32'h1);
            @(negedge clk);
            chk("R8 err one cycle", {31'b0, bus_err}, 32'h0);
        end
        do_read(A_CFG, v);  chk("R8 cfg after unmapped", v, {16'h0, cfg_m});
        do_read(A_LANE, v); chk("R9 lane after unmapped", v, {16'h0, lane_m});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule